// File: doc/BRIEF.md
# In-Order Load-Store Queue

This block holds memory instructions in a circular buffer of `DEPTH` slots, in the order the issue stage hands them over. Each slot keeps the instruction word, a 12-bit immediate, the reorder-buffer tag of the instruction and up to two source operands. Every operand has a present flag, a ready flag, the tag of the instruction that will produce it, and its value. Only the oldest slot may send a request to memory. It does so once each of its operands is absent or ready. The request carries the address (operand 1 plus the sign-extended immediate), the store data (operand 2), the reorder-buffer tag and the instruction word.

Operand values reach a slot in three ways. In the cycle after allocation, a lookup answer comes from the register file or from the reorder buffer. After that, a slot snoops two result broadcasts, one from the ALU and one from memory. A slot that was allocated in the previous cycle gets its operands resolved from the lookup answer. In that same cycle it also compares the lookup's producer tag against both broadcasts, so a result that appears exactly then is not lost. The issue stage reads the free-slot count. A flush input empties the queue in one cycle.

Top module: `lsq_inorder`

## Requirements
- R1: After reset, `free_space` equals `DEPTH` (32) and `req_kind` is 0.
- R2: An allocation request is accepted only when `free_space` is nonzero, and each accepted allocation lowers `free_space` by one. A request made while `free_space` is 0 stores nothing and never produces a memory request.
- R3: Requests leave strictly in allocation order, and only from the oldest slot. A younger slot whose operands are ready still waits behind an older slot whose operand is pending.
- R4: A request has `req_kind` 1 for a load and 2 for a store. `req_addr` is operand 1 plus the 12-bit immediate sign-extended to 32 bits, `req_data` is operand 2, and an absent operand counts as 0. `req_rob` and `req_ins` carry the slot's tag and instruction word. The request appears one cycle after the slot becomes issuable.
- R5: Each issue raises `free_space` by one. An accepted allocation and an issue in the same cycle leave `free_space` unchanged.
- R6: In every cycle without an issue, `req_kind` is 0, so each slot produces exactly one request cycle.
- R7: A broadcast bus is used only while its status equals binary 10. Any other status wakes no operand.
- R8: A pending operand takes a broadcast value and becomes ready only when the broadcast tag equals its producer tag. An operand that is already ready ignores later broadcasts that carry a matching tag.
- R9: In the cycle after allocation, a present operand takes the register-file value when the lookup reports no dependency, or else the reorder-buffer value when the lookup reports the producer done. Otherwise it records the lookup tag, and it also takes a broadcast in that same cycle whose tag matches the lookup tag.
- R10: Head and tail wrap modulo `DEPTH`, and order is kept across the wrap.
- R11: `flush` empties the queue in one cycle. The following cycle shows `free_space` equal to `DEPTH` and `req_kind` 0. An allocation presented with the flush is dropped, and the discarded slots never issue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Empty the queue this cycle |
| alloc_valid | input | 1 | Allocation request |
| alloc_store | input | 1 | 1 = store, 0 = load |
| alloc_ins | input | INS_W | Instruction word |
| alloc_imm | input | IMM_W | Immediate, sign-extended for the address |
| alloc_rob | input | TAG_W | Reorder-buffer tag of the instruction |
| alloc_use1 | input | 1 | Operand 1 present |
| alloc_use2 | input | 1 | Operand 2 present |
| lk1_nodep | input | 1 | Operand 1 lookup: no pending producer |
| lk1_reg_val | input | DATA_W | Operand 1 register-file value |
| lk1_tag | input | TAG_W | Operand 1 producer tag |
| lk1_done | input | 1 | Operand 1 producer already finished |
| lk1_rob_val | input | DATA_W | Operand 1 value held by the reorder buffer |
| lk2_nodep | input | 1 | Operand 2 lookup: no pending producer |
| lk2_reg_val | input | DATA_W | Operand 2 register-file value |
| lk2_tag | input | TAG_W | Operand 2 producer tag |
| lk2_done | input | 1 | Operand 2 producer already finished |
| lk2_rob_val | input | DATA_W | Operand 2 value held by the reorder buffer |
| alu_status | input | 2 | ALU broadcast status, 2'b10 = valid |
| alu_tag | input | TAG_W | ALU broadcast tag |
| alu_val | input | DATA_W | ALU broadcast value |
| mem_status | input | 2 | Memory broadcast status, 2'b10 = valid |
| mem_tag | input | TAG_W | Memory broadcast tag |
| mem_val | input | DATA_W | Memory broadcast value |
| free_space | output | CNT_W | Number of free slots |
| req_kind | output | 2 | 0 none, 1 load, 2 store |
| req_addr | output | DATA_W | Request address |
| req_data | output | DATA_W | Store data |
| req_rob | output | TAG_W | Tag of the issuing instruction |
| req_ins | output | INS_W | Instruction word of the issuing slot |

## Verification
Allocation and head issue can land on the same edge. The bench provokes this by presenting a new allocation while a full queue drains one request per cycle, and then requires `free_space` to be the same before and after that edge. The second collision is a broadcast during a fresh slot's lookup cycle. The bench drives a matching ALU result exactly in the lookup cycle, and the scoreboard requires the later request address to be built from that broadcast value.

// File: rtl/lsq_pkg.sv
package lsq_pkg;

  typedef enum logic [1:0] {
    REQ_NONE  = 2'd0,
    REQ_LOAD  = 2'd1,
    REQ_STORE = 2'd2
  } req_kind_e;

  // status code of a result bus that carries a valid result
  localparam logic [1:0] BUS_LIVE = 2'b10;

endpackage

// File: rtl/lsq_src_cell.sv
module lsq_src_cell #(
  parameter int TAG_W  = 5,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              alloc_here,
  input  logic              alloc_use,
  input  logic              fresh_here,
  input  logic              lk_nodep,
  input  logic [DATA_W-1:0] lk_reg_val,
  input  logic [TAG_W-1:0]  lk_tag,
  input  logic              lk_done,
  input  logic [DATA_W-1:0] lk_rob_val,
  input  logic              alu_live,
  input  logic [TAG_W-1:0]  alu_tag,
  input  logic [DATA_W-1:0] alu_val,
  input  logic              mem_live,
  input  logic [TAG_W-1:0]  mem_tag,
  input  logic [DATA_W-1:0] mem_val,
  output logic              src_ok,
  output logic [DATA_W-1:0] src_val
);

  logic              ex_q, ex_n;
  logic              rdy_q, rdy_n;
  logic [TAG_W-1:0]  tag_q, tag_n;
  logic [DATA_W-1:0] val_q, val_n;
  logic              upd;
  logic              pending;
  logic [TAG_W-1:0]  look_tag;
  logic              alu_hit, mem_hit;

  assign pending  = ex_q && !rdy_q;
  assign look_tag = fresh_here ? lk_tag : tag_q;
  assign alu_hit  = alu_live && (alu_tag == look_tag);
  assign mem_hit  = mem_live && (mem_tag == look_tag);

  always_comb begin
    upd   = 1'b0;
    ex_n  = ex_q;
    rdy_n = rdy_q;
    tag_n = tag_q;
    val_n = val_q;
    if (flush) begin
      upd   = 1'b1;
      ex_n  = 1'b0;
      rdy_n = 1'b1;
    end else if (alloc_here) begin
      upd   = 1'b1;
      ex_n  = alloc_use;
      rdy_n = !alloc_use;
      tag_n = '0;
      val_n = '0;
    end else if (pending) begin
      if (fresh_here && lk_nodep) begin
        upd   = 1'b1;
        rdy_n = 1'b1;
        val_n = lk_reg_val;
      end else if (fresh_here && lk_done) begin
        upd   = 1'b1;
        rdy_n = 1'b1;
        val_n = lk_rob_val;
      end else if (alu_hit) begin
        upd   = 1'b1;
        rdy_n = 1'b1;
        val_n = alu_val;
      end else if (mem_hit) begin
        upd   = 1'b1;
        rdy_n = 1'b1;
        val_n = mem_val;
      end else if (fresh_here) begin
        upd   = 1'b1;
        tag_n = lk_tag;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ex_q  <= 1'b0;
      rdy_q <= 1'b1;
      tag_q <= '0;
      val_q <= '0;
    end else if (upd) begin
      ex_q  <= ex_n;
      rdy_q <= rdy_n;
      tag_q <= tag_n;
      val_q <= val_n;
    end
  end

  assign src_ok  = !ex_q || rdy_q;
  assign src_val = val_q;

  // R8: a ready operand keeps its value until the slot is reused
  a_r8_ready_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_q && rdy_q && !alloc_here && !flush) |=> (rdy_q && $stable(val_q)));

  // R7: with no live bus and no lookup, a pending operand stays pending
  a_r7_no_wake: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !fresh_here && !alloc_here && !flush && !alu_live && !mem_live)
      |=> (!rdy_q && $stable(tag_q)));

endmodule

// File: rtl/lsq_ring_ctl.sv
module lsq_ring_ctl #(
  parameter int DEPTH = 32,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             alloc_req,
  input  logic             issue_go,
  output logic [PTR_W-1:0] head_q,
  output logic [PTR_W-1:0] tail_q,
  output logic [CNT_W-1:0] free_q,
  output logic             alloc_ok,
  output logic             empty,
  output logic             fresh_vld_q,
  output logic [PTR_W-1:0] fresh_idx_q
);

  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_FREE = CNT_W'(DEPTH);

  logic [PTR_W-1:0] head_n, tail_n, fresh_idx_n;
  logic [CNT_W-1:0] free_n;
  logic             fresh_vld_n;
  logic             hd_en, tl_en, cnt_en;

  function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  assign alloc_ok = alloc_req && (free_q != '0) && !flush;
  assign empty    = (free_q == FULL_FREE);

  assign hd_en  = flush || issue_go;
  assign tl_en  = flush || alloc_ok;
  assign cnt_en = flush || (alloc_ok ^ issue_go);

  always_comb begin
    head_n      = flush ? '0 : step(head_q);
    tail_n      = flush ? '0 : step(tail_q);
    if (flush)         free_n = FULL_FREE;
    else if (issue_go) free_n = free_q + 1'b1;
    else               free_n = free_q - 1'b1;
    fresh_vld_n = alloc_ok;
    fresh_idx_n = alloc_ok ? tail_q : fresh_idx_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
    end else if (hd_en) begin
      head_q <= head_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tail_q <= '0;
    end else if (tl_en) begin
      tail_q <= tail_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      free_q <= FULL_FREE;
    end else if (cnt_en) begin
      free_q <= free_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fresh_vld_q <= 1'b0;
      fresh_idx_q <= '0;
    end else begin
      fresh_vld_q <= fresh_vld_n;
      fresh_idx_q <= fresh_idx_n;
    end
  end

  // R5: outside a flush, the free count moves by at most one per cycle
  a_r5_free_step: assert property (@(posedge clk) disable iff (!rst_n)
    !flush |=> ((free_q <= $past(free_q) + 1'b1) && ($past(free_q) <= free_q + 1'b1)));

  // R2: a full queue does not move its tail
  a_r2_full_tail_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ((free_q == '0) && !flush) |=> $stable(tail_q));

  // R11: a flush leaves an empty ring
  a_r11_flush_empty: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> ((free_q == FULL_FREE) && (head_q == tail_q) && !fresh_vld_q));

  // R3: nothing issues from an empty ring
  a_r3_issue_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    issue_go |-> !empty);

endmodule

// File: rtl/lsq_req_stage.sv
module lsq_req_stage
  import lsq_pkg::*;
#(
  parameter int TAG_W  = 5,
  parameter int DATA_W = 32,
  parameter int INS_W  = 32,
  parameter int IMM_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              is_store,
  input  logic [DATA_W-1:0] base,
  input  logic [IMM_W-1:0]  imm,
  input  logic [DATA_W-1:0] wdata,
  input  logic [TAG_W-1:0]  rob,
  input  logic [INS_W-1:0]  ins,
  output logic [1:0]        req_kind,
  output logic [DATA_W-1:0] req_addr,
  output logic [DATA_W-1:0] req_data,
  output logic [TAG_W-1:0]  req_rob,
  output logic [INS_W-1:0]  req_ins
);

  req_kind_e         kind_q, kind_n;
  logic [DATA_W-1:0] addr_n;
  logic [DATA_W-1:0] imm_ext;

  assign imm_ext = {{(DATA_W - IMM_W){imm[IMM_W-1]}}, imm};
  assign addr_n  = base + imm_ext;

  always_comb begin
    kind_n = REQ_NONE;
    if (go) kind_n = is_store ? REQ_STORE : REQ_LOAD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q <= REQ_NONE;
    end else begin
      kind_q <= kind_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_addr <= '0;
      req_data <= '0;
      req_rob  <= '0;
      req_ins  <= '0;
    end else if (go) begin
      req_addr <= addr_n;
      req_data <= wdata;
      req_rob  <= rob;
      req_ins  <= ins;
    end
  end

  assign req_kind = kind_q;

  // R6: while idle the payload holds, so a request is never re-formed silently
  a_r6_idle_payload: assert property (@(posedge clk) disable iff (!rst_n)
    (kind_q == REQ_NONE && !go) |=> (kind_q == REQ_NONE && $stable(req_addr) && $stable(req_rob)));

endmodule

// File: rtl/lsq_inorder.sv
module lsq_inorder
  import lsq_pkg::*;
#(
  parameter int DEPTH  = 32,
  parameter int TAG_W  = 5,
  parameter int DATA_W = 32,
  parameter int INS_W  = 32,
  parameter int IMM_W  = 12,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              alloc_valid,
  input  logic              alloc_store,
  input  logic [INS_W-1:0]  alloc_ins,
  input  logic [IMM_W-1:0]  alloc_imm,
  input  logic [TAG_W-1:0]  alloc_rob,
  input  logic              alloc_use1,
  input  logic              alloc_use2,
  input  logic              lk1_nodep,
  input  logic [DATA_W-1:0] lk1_reg_val,
  input  logic [TAG_W-1:0]  lk1_tag,
  input  logic              lk1_done,
  input  logic [DATA_W-1:0] lk1_rob_val,
  input  logic              lk2_nodep,
  input  logic [DATA_W-1:0] lk2_reg_val,
  input  logic [TAG_W-1:0]  lk2_tag,
  input  logic              lk2_done,
  input  logic [DATA_W-1:0] lk2_rob_val,
  input  logic [1:0]        alu_status,
  input  logic [TAG_W-1:0]  alu_tag,
  input  logic [DATA_W-1:0] alu_val,
  input  logic [1:0]        mem_status,
  input  logic [TAG_W-1:0]  mem_tag,
  input  logic [DATA_W-1:0] mem_val,
  output logic [CNT_W-1:0]  free_space,
  output logic [1:0]        req_kind,
  output logic [DATA_W-1:0] req_addr,
  output logic [DATA_W-1:0] req_data,
  output logic [TAG_W-1:0]  req_rob,
  output logic [INS_W-1:0]  req_ins
);

  localparam int NSRC = 2;

  logic [PTR_W-1:0] head_q, tail_q, fresh_idx_q;
  logic [CNT_W-1:0] free_q;
  logic             alloc_ok, empty, fresh_vld_q;
  logic             issue_go;
  logic             alu_live, mem_live;

  // per-operand lookup answers, index 0 = operand 1
  logic [NSRC-1:0]   lk_nodep_v, lk_done_v, use_v;
  logic [DATA_W-1:0] lk_reg_v [NSRC];
  logic [DATA_W-1:0] lk_rob_v [NSRC];
  logic [TAG_W-1:0]  lk_tag_v [NSRC];

  // slot payload
  logic [INS_W-1:0]  ins_q [DEPTH];
  logic [IMM_W-1:0]  imm_q [DEPTH];
  logic [TAG_W-1:0]  rob_q [DEPTH];
  logic [DEPTH-1:0]  st_q;

  logic [NSRC-1:0]   src_ok  [DEPTH];
  logic [DATA_W-1:0] src_val [DEPTH][NSRC];

  assign alu_live = (alu_status == BUS_LIVE);
  assign mem_live = (mem_status == BUS_LIVE);

  assign lk_nodep_v = {lk2_nodep, lk1_nodep};
  assign lk_done_v  = {lk2_done, lk1_done};
  assign use_v      = {alloc_use2, alloc_use1};
  assign lk_reg_v[0] = lk1_reg_val;
  assign lk_reg_v[1] = lk2_reg_val;
  assign lk_rob_v[0] = lk1_rob_val;
  assign lk_rob_v[1] = lk2_rob_val;
  assign lk_tag_v[0] = lk1_tag;
  assign lk_tag_v[1] = lk2_tag;

  lsq_ring_ctl #(.DEPTH(DEPTH)) u_ring (
    .clk         (clk),
    .rst_n       (rst_n),
    .flush       (flush),
    .alloc_req   (alloc_valid),
    .issue_go    (issue_go),
    .head_q      (head_q),
    .tail_q      (tail_q),
    .free_q      (free_q),
    .alloc_ok    (alloc_ok),
    .empty       (empty),
    .fresh_vld_q (fresh_vld_q),
    .fresh_idx_q (fresh_idx_q)
  );

  for (genvar e = 0; e < DEPTH; e++) begin : g_slot
    logic wr_here, fresh_here;
    assign wr_here    = alloc_ok && (tail_q == PTR_W'(e));
    assign fresh_here = fresh_vld_q && (fresh_idx_q == PTR_W'(e)) && !flush;

    always_ff @(posedge clk) begin
      if (wr_here) begin
        ins_q[e] <= alloc_ins;
        imm_q[e] <= alloc_imm;
        rob_q[e] <= alloc_rob;
        st_q[e]  <= alloc_store;
      end
    end

    for (genvar s = 0; s < NSRC; s++) begin : g_src
      lsq_src_cell #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_cell (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (flush),
        .alloc_here (wr_here),
        .alloc_use  (use_v[s]),
        .fresh_here (fresh_here),
        .lk_nodep   (lk_nodep_v[s]),
        .lk_reg_val (lk_reg_v[s]),
        .lk_tag     (lk_tag_v[s]),
        .lk_done    (lk_done_v[s]),
        .lk_rob_val (lk_rob_v[s]),
        .alu_live   (alu_live),
        .alu_tag    (alu_tag),
        .alu_val    (alu_val),
        .mem_live   (mem_live),
        .mem_tag    (mem_tag),
        .mem_val    (mem_val),
        .src_ok     (src_ok[e][s]),
        .src_val    (src_val[e][s])
      );
    end
  end

  assign issue_go = !empty && !flush && (&src_ok[head_q]);

  lsq_req_stage #(
    .TAG_W(TAG_W), .DATA_W(DATA_W), .INS_W(INS_W), .IMM_W(IMM_W)
  ) u_req (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (issue_go),
    .is_store (st_q[head_q]),
    .base     (src_val[head_q][0]),
    .imm      (imm_q[head_q]),
    .wdata    (src_val[head_q][1]),
    .rob      (rob_q[head_q]),
    .ins      (ins_q[head_q]),
    .req_kind (req_kind),
    .req_addr (req_addr),
    .req_data (req_data),
    .req_rob  (req_rob),
    .req_ins  (req_ins)
  );

  assign free_space = free_q;

  // R3: a request is only produced if the queue held a slot one cycle earlier
  a_r3_req_has_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (req_kind != REQ_NONE) |-> ($past(free_space) != CNT_W'(DEPTH)));

  // R11: after a flush no request is presented
  a_r11_flush_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (req_kind == REQ_NONE));

endmodule

// File: tb/sim_lsq_inorder.sv
`timescale 1ns/1ps
module sim_lsq_inorder;

  localparam int DEPTH = 32;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        flush;
  logic        alloc_valid, alloc_store, alloc_use1, alloc_use2;
  logic [31:0] alloc_ins;
  logic [11:0] alloc_imm;
  logic [4:0]  alloc_rob;
  logic        lk1_nodep, lk1_done, lk2_nodep, lk2_done;
  logic [31:0] lk1_reg_val, lk1_rob_val, lk2_reg_val, lk2_rob_val;
  logic [4:0]  lk1_tag, lk2_tag;
  logic [1:0]  alu_status, mem_status;
  logic [4:0]  alu_tag, mem_tag;
  logic [31:0] alu_val, mem_val;
  logic [5:0]  free_space;
  logic [1:0]  req_kind;
  logic [31:0] req_addr, req_data, req_ins;
  logic [4:0]  req_rob;

  typedef struct packed {
    logic [1:0]  kind;
    logic [31:0] addr;
    logic [31:0] data;
    logic [4:0]  rob;
    logic [31:0] ins;
  } exp_t;

  exp_t sb[$];
  int   checks = 0;
  int   errors = 0;
  bit   done = 0;

  logic        side_en = 1'b0;
  logic [4:0]  side_tag = '0;
  logic [31:0] side_val = '0;

  always #10 clk = ~clk;

  lsq_inorder u0 (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .alloc_valid(alloc_valid), .alloc_store(alloc_store), .alloc_ins(alloc_ins),
    .alloc_imm(alloc_imm), .alloc_rob(alloc_rob), .alloc_use1(alloc_use1), .alloc_use2(alloc_use2),
    .lk1_nodep(lk1_nodep), .lk1_reg_val(lk1_reg_val), .lk1_tag(lk1_tag), .lk1_done(lk1_done),
    .lk1_rob_val(lk1_rob_val),
    .lk2_nodep(lk2_nodep), .lk2_reg_val(lk2_reg_val), .lk2_tag(lk2_tag), .lk2_done(lk2_done),
    .lk2_rob_val(lk2_rob_val),
    .alu_status(alu_status), .alu_tag(alu_tag), .alu_val(alu_val),
    .mem_status(mem_status), .mem_tag(mem_tag), .mem_val(mem_val),
    .free_space(free_space), .req_kind(req_kind), .req_addr(req_addr),
    .req_data(req_data), .req_rob(req_rob), .req_ins(req_ins)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] sx(input logic [11:0] i);
    return {{20{i[11]}}, i};
  endfunction

  task automatic push(input logic st, input logic [31:0] addr, input logic [31:0] data,
                      input logic [4:0] rob, input logic [31:0] ins);
    exp_t e;
    e.kind = st ? 2'd2 : 2'd1;
    e.addr = addr; e.data = data; e.rob = rob; e.ins = ins;
    sb.push_back(e);
  endtask

  // monitor: every request cycle must match the oldest expected item (R3 R4 R6)
  always @(negedge clk) begin
    if (rst_n && req_kind != 2'd0) begin
      checks++;
      if (sb.size() == 0) begin
        errors++;
        $display("FAIL R3 unexpected request actual kind=%0d ins=%h expected none", req_kind, req_ins);
      end else begin
        exp_t e;
        e = sb.pop_front();
        if ({req_kind, req_addr, req_data, req_rob, req_ins} != e) begin
          errors++;
          $display("FAIL R4 request actual kind=%0d addr=%h data=%h rob=%0d ins=%h expected kind=%0d addr=%h data=%h rob=%0d ins=%h",
                   req_kind, req_addr, req_data, req_rob, req_ins, e.kind, e.addr, e.data, e.rob, e.ins);
        end
      end
    end
  end

  task automatic idle_inputs();
    flush = 0; alloc_valid = 0; alloc_store = 0; alloc_ins = '0; alloc_imm = '0; alloc_rob = '0;
    alloc_use1 = 0; alloc_use2 = 0;
    lk1_nodep = 0; lk1_reg_val = '0; lk1_tag = '0; lk1_done = 0; lk1_rob_val = '0;
    lk2_nodep = 0; lk2_reg_val = '0; lk2_tag = '0; lk2_done = 0; lk2_rob_val = '0;
    alu_status = 0; alu_tag = '0; alu_val = '0; mem_status = 0; mem_tag = '0; mem_val = '0;
  endtask

  // operand mode: 0 absent, 1 register value, 2 reorder-buffer value, 3 wait on tag
  task automatic put(input logic st, input logic [31:0] ins, input logic [11:0] imm, input logic [4:0] rob,
                     input int m1, input logic [31:0] v1, input logic [4:0] t1,
                     input int m2, input logic [31:0] v2, input logic [4:0] t2);
    @(negedge clk);
    alloc_valid = 1; alloc_store = st; alloc_ins = ins; alloc_imm = imm; alloc_rob = rob;
    alloc_use1 = (m1 != 0); alloc_use2 = (m2 != 0);
    @(negedge clk);
    alloc_valid = 0;
    lk1_nodep = (m1 == 1); lk1_done = (m1 == 2); lk1_reg_val = v1; lk1_rob_val = v1; lk1_tag = t1;
    lk2_nodep = (m2 == 1); lk2_done = (m2 == 2); lk2_reg_val = v2; lk2_rob_val = v2; lk2_tag = t2;
    if (side_en) begin alu_status = 2'b10; alu_tag = side_tag; alu_val = side_val; end
    @(negedge clk);
    lk1_nodep = 0; lk1_done = 0; lk1_tag = '0; lk2_nodep = 0; lk2_done = 0; lk2_tag = '0;
    alu_status = 0;
  endtask

  task automatic bcast(input bit on_alu, input logic [1:0] st, input logic [4:0] tag, input logic [31:0] val);
    @(negedge clk);
    if (on_alu) begin alu_status = st; alu_tag = tag; alu_val = val; end
    else        begin mem_status = st; mem_tag = tag; mem_val = val; end
    @(negedge clk);
    alu_status = 0; mem_status = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [5:0] f0;
    idle_inputs();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(free_space == 6'd32, "R1 free after reset", 32'(free_space), 32);
    chk(req_kind == 2'd0, "R1 kind after reset", 32'(req_kind), 0);

    // single load, register operand, negative offset
    push(0, 32'h0000_1000 + sx(12'hFFC), 32'h0, 5'd1, 32'hA001);
    put(0, 32'hA001, 12'hFFC, 5'd1, 1, 32'h1000, 5'd0, 0, 32'h0, 5'd0);
    chk(free_space == 6'd31, "R2 free after one alloc", 32'(free_space), 31);
    repeat (3) @(negedge clk);
    chk(free_space == 6'd32, "R5 free after issue", 32'(free_space), 32);

    // store, operand 1 from the reorder buffer, operand 2 from the register file (R9)
    push(1, 32'h2000_0000 + sx(12'h7FF), 32'hDEAD_BEEF, 5'd2, 32'hB002);
    put(1, 32'hB002, 12'h7FF, 5'd2, 2, 32'h2000_0000, 5'd0, 1, 32'hDEAD_BEEF, 5'd0);
    repeat (4) @(negedge clk);

    // head blocked, younger ready slot waits (R3); non-10 status ignored (R7)
    push(0, 32'h4000 + 32'h10, 32'h0, 5'd4, 32'hC003);
    push(0, 32'h20, 32'h0, 5'd5, 32'hC004);
    put(0, 32'hC003, 12'h010, 5'd4, 3, 32'h0, 5'd3, 0, 32'h0, 5'd0);
    put(0, 32'hC004, 12'h020, 5'd5, 0, 32'h0, 5'd0, 0, 32'h0, 5'd0);
    repeat (4) @(negedge clk);
    chk(free_space == 6'd30, "R3 younger waits behind head", 32'(free_space), 30);
    bcast(1, 2'b01, 5'd3, 32'h5555);
    bcast(0, 2'b11, 5'd3, 32'h6666);
    repeat (2) @(negedge clk);
    chk(free_space == 6'd30, "R7 status other than 10 ignored", 32'(free_space), 30);
    bcast(0, 2'b10, 5'd3, 32'h4000);
    repeat (5) @(negedge clk);
    chk(free_space == 6'd32, "R3 both issued in order", 32'(free_space), 32);

    // ready operand ignores a later matching broadcast (R8)
    push(1, 32'h0001_0000 + sx(12'h800), 32'hCAFE_0001, 5'd6, 32'hD005);
    put(1, 32'hD005, 12'h800, 5'd6, 3, 32'h0, 5'd7, 3, 32'h0, 5'd9);
    bcast(1, 2'b10, 5'd7, 32'h0001_0000);
    bcast(0, 2'b10, 5'd7, 32'h0009_9999);
    repeat (2) @(negedge clk);
    chk(free_space == 6'd31, "R8 store waits for operand 2", 32'(free_space), 31);
    bcast(1, 2'b10, 5'd9, 32'hCAFE_0001);
    repeat (4) @(negedge clk);

    // broadcast in the lookup cycle of a fresh slot (R9)
    push(0, 32'h3004, 32'h0, 5'd7, 32'hE006);
    side_en = 1; side_tag = 5'd12; side_val = 32'h3000;
    put(0, 32'hE006, 12'h004, 5'd7, 3, 32'h0, 5'd12, 0, 32'h0, 5'd0);
    side_en = 0;
    repeat (4) @(negedge clk);
    chk(free_space == 6'd32, "R9 same-cycle capture issued", 32'(free_space), 32);

    // fill to full across the wrap, refuse the extra, drain (R2 R5 R10)
    push(0, 32'h7000, 32'h0, 5'd8, 32'hF000);
    for (int i = 1; i < DEPTH; i++) push(0, 32'(i * 4), 32'h0, 5'((8 + i) % 32), 32'hF000 + 32'(i));
    put(0, 32'hF000, 12'h000, 5'd8, 3, 32'h0, 5'd20, 0, 32'h0, 5'd0);
    for (int i = 1; i < DEPTH; i++) begin
      @(negedge clk);
      alloc_valid = 1; alloc_store = 0; alloc_ins = 32'hF000 + 32'(i); alloc_imm = 12'(i * 4);
      alloc_rob = 5'((8 + i) % 32); alloc_use1 = 0; alloc_use2 = 0;
    end
    @(negedge clk);
    chk(free_space == 6'd0, "R2 queue full", 32'(free_space), 0);
    alloc_ins = 32'h0000_BAD0; alloc_imm = 12'h0; alloc_rob = 5'd31;
    @(negedge clk);
    alloc_valid = 0;
    chk(free_space == 6'd0, "R2 alloc refused when full", 32'(free_space), 0);
    bcast(1, 2'b10, 5'd20, 32'h7000);
    repeat (3) @(negedge clk);
    f0 = free_space;
    chk(f0 == 6'd3, "R5 one issue per cycle", 32'(f0), 3);
    push(0, 32'h40, 32'h0, 5'd30, 32'h0000_AB00);
    alloc_valid = 1; alloc_ins = 32'h0000_AB00; alloc_imm = 12'h040; alloc_rob = 5'd30;
    @(negedge clk);
    alloc_valid = 0;
    chk(free_space == f0, "R5 alloc and issue same cycle", 32'(free_space), 32'(f0));
    repeat (40) @(negedge clk);
    chk(free_space == 6'd32, "R10 drained across wrap", 32'(free_space), 32);

    // flush drops waiting slots and a same-cycle allocation (R11)
    put(0, 32'h1111, 12'h0, 5'd1, 3, 32'h0, 5'd25, 0, 32'h0, 5'd0);
    put(1, 32'h1112, 12'h0, 5'd2, 3, 32'h0, 5'd25, 3, 32'h0, 5'd25);
    @(negedge clk);
    flush = 1; alloc_valid = 1; alloc_ins = 32'h2222; alloc_use1 = 0; alloc_use2 = 0;
    @(negedge clk);
    flush = 0; alloc_valid = 0;
    chk(free_space == 6'd32, "R11 free after flush", 32'(free_space), 32);
    chk(req_kind == 2'd0, "R11 no request after flush", 32'(req_kind), 0);
    bcast(1, 2'b10, 5'd25, 32'h9999);
    repeat (4) @(negedge clk);
    chk(free_space == 6'd32, "R11 flushed slots never issue", 32'(free_space), 32);
    push(0, 32'h8, 32'h0, 5'd2, 32'h3333);
    put(0, 32'h3333, 12'h008, 5'd2, 0, 32'h0, 5'd0, 0, 32'h0, 5'd0);
    repeat (4) @(negedge clk);

    chk(sb.size() == 0, "R3 every expected request seen", 32'(sb.size()), 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule